// File: doc/BRIEF.md
# Programmable-Increment System Time Counter

A free-running 64-bit time base for precision timestamping. The counter does not step by one every clock. A 32-bit increment-control register holds two fields. An 8-bit period field sets how many reference-clock cycles pass between updates. A 24-bit value field sets the amount added at each update. Software shifts the value field left before writing it, so the low bits of the count are fractions of a nanosecond and the upper bits count whole nanoseconds. The count wraps silently at 2^64.

Software trims the frequency by rewriting the control register at any time. The count is never reset by such a write. A read of the low half latches the high half into a shadow register, so a low read followed by a high read returns one coherent 64-bit time. A new time is loaded in two steps. A write to the low half is only staged. The following write to the high half loads all 64 bits in one cycle.

Top module: `systime_counter`

## Requirements
- R1: After synchronous reset, the count, the control register, the staged low word, the shadow and the read data are all zero, so counting is off.
- R2: Register addresses are 0 = time low, 1 = time high, 2 = increment control, 3 = unused. Read data appears on `rd_data` in the cycle after `rd_en`, qualified by `rd_valid`, which is high for that one cycle.
- R3: With control bits 31:24 = P > 0, the count updates once every P cycles. The first update comes P cycles after the last control write or time load.
- R4: Each update adds control bits 23:0, zero-extended to 64 bits, in one cycle.
- R5: With a period field of 0, the count holds its value.
- R6: A control write restarts the period divider and keeps the current count. The update that would fall in the cycle of that write is dropped.
- R7: A low read returns the live low half and copies the live high half into the shadow in the same cycle. A high read returns the shadow, not the live high half.
- R8: A low write only stages its data. A high write loads {high data, staged low} into the count at once, clears the divider and takes priority over an update in that cycle.
- R9: The carry out of the low half enters the high half within the same update, and the count wraps modulo 2^64.
- R10: Address 3 reads as zero, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register select |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| rd_valid | output | 1 | High one cycle after a read strobe |

## Verification
Every read result is due exactly one cycle after its strobe. It reflects the count as it stood just before that clock edge. An update first shows in reads issued P+1 cycles after the write that restarted the divider. A behavioural model in the bench advances on the same edges, and the bench compares against it on the falling edge of every cycle. Directed cases turn these offsets into closed-form expected values: the period spacing, the divider restart, the wrap with carry, and the shadow coherence.

// File: rtl/systime_pkg.sv
package systime_pkg;
  localparam int REG_ADDR_W = 2;
  typedef enum logic [REG_ADDR_W-1:0] {
    RA_TIME_LO  = 2'd0,
    RA_TIME_HI  = 2'd1,
    RA_INC_CTRL = 2'd2,
    RA_SPARE    = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/systime_tick_div.sv
module systime_tick_div #(
  parameter int PER_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic [PER_W-1:0] period,
  output logic             step
);
  logic [PER_W-1:0] cnt_q;
  logic             active;
  logic             at_end;

  assign active = (period != '0);
  assign at_end = (cnt_q == period - PER_W'(1));
  assign step   = active && at_end && !restart;

  always_ff @(posedge clk) begin
    if (rst || restart || !active) cnt_q <= '0;
    else if (at_end)                cnt_q <= '0;
    else                            cnt_q <= cnt_q + PER_W'(1);
  end

  AST_DIV_BELOW_PERIOD: assert property (@(posedge clk) disable iff (rst)
    (period != '0) |-> (cnt_q < period)); // R3
endmodule

// File: rtl/systime_accum.sv
module systime_accum #(
  parameter int TIME_W = 64,
  parameter int INC_W  = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  input  logic [INC_W-1:0]  inc,
  input  logic              load,
  input  logic [TIME_W-1:0] load_val,
  output logic [TIME_W-1:0] time_q
);
  localparam int HALF_W = TIME_W / 2;

  logic [HALF_W-1:0] lo_q, hi_q;
  logic [HALF_W-1:0] lo_sum;
  logic              lo_carry;

  assign {lo_carry, lo_sum} = {1'b0, lo_q} + (HALF_W+1)'(inc);

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (load) begin
      lo_q <= load_val[HALF_W-1:0];
      hi_q <= load_val[TIME_W-1:HALF_W];
    end else if (step) begin
      lo_q <= lo_sum;
      hi_q <= hi_q + HALF_W'(lo_carry);
    end
  end

  assign time_q = {hi_q, lo_q};

  AST_STEP_ADDS: assert property (@(posedge clk) disable iff (rst)
    ($past(step) && !$past(load)) |-> (time_q == $past(time_q) + TIME_W'($past(inc)))); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!$past(step) && !$past(load)) |-> $stable(time_q)); // R5
  AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (rst)
    $past(load) |-> (time_q == $past(load_val))); // R8
endmodule

// File: rtl/systime_regif.sv
module systime_regif
  import systime_pkg::*;
#(
  parameter int TIME_W = 64,
  parameter int CTRL_W = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic                  rd_en,
  input  logic [REG_ADDR_W-1:0] addr,
  input  logic [TIME_W/2-1:0]   wr_data,
  input  logic [TIME_W-1:0]     time_q,
  output logic [CTRL_W-1:0]     ctrl_q,
  output logic                  load,
  output logic [TIME_W-1:0]     load_val,
  output logic                  restart,
  output logic [TIME_W/2-1:0]   rd_data,
  output logic                  rd_valid
);
  localparam int HALF_W = TIME_W / 2;

  logic [HALF_W-1:0] stage_q;
  logic [HALF_W-1:0] shadow_q;
  logic              ctrl_wr;
  logic              lo_rd;

  assign ctrl_wr  = wr_en && (addr == RA_INC_CTRL);
  assign load     = wr_en && (addr == RA_TIME_HI);
  assign load_val = {wr_data, stage_q};
  assign restart  = ctrl_wr || load;
  assign lo_rd    = rd_en && (addr == RA_TIME_LO);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      stage_q <= '0;
    end else if (wr_en) begin
      if (addr == RA_INC_CTRL) ctrl_q  <= CTRL_W'(wr_data);
      if (addr == RA_TIME_LO)  stage_q <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_q <= '0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (lo_rd) shadow_q <= time_q[TIME_W-1:HALF_W];
      if (rd_en) begin
        case (addr)
          RA_TIME_LO:  rd_data <= time_q[HALF_W-1:0];
          RA_TIME_HI:  rd_data <= shadow_q;
          RA_INC_CTRL: rd_data <= HALF_W'(ctrl_q);
          default:     rd_data <= '0;
        endcase
      end
    end
  end

  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$past(lo_rd) |-> $stable(shadow_q)); // R7
  AST_SPARE_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    ($past(rd_en) && ($past(addr) == RA_SPARE)) |-> (rd_data == '0)); // R10
endmodule

// File: rtl/systime_counter.sv
module systime_counter
  import systime_pkg::*;
#(
  parameter int TIME_W = 64,
  parameter int PER_W  = 8,
  parameter int INC_W  = 24
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic                  rd_en,
  input  logic [REG_ADDR_W-1:0] addr,
  input  logic [TIME_W/2-1:0]   wr_data,
  output logic [TIME_W/2-1:0]   rd_data,
  output logic                  rd_valid
);
  localparam int CTRL_W = PER_W + INC_W;

  logic [CTRL_W-1:0] ctrl_q;
  logic              load, restart, step;
  logic [TIME_W-1:0] load_val, time_q;

  systime_regif #(.TIME_W(TIME_W), .CTRL_W(CTRL_W)) u_regif (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .time_q(time_q), .ctrl_q(ctrl_q), .load(load),
    .load_val(load_val), .restart(restart), .rd_data(rd_data),
    .rd_valid(rd_valid)
  );

  systime_tick_div #(.PER_W(PER_W)) u_div (
    .clk(clk), .rst(rst), .restart(restart),
    .period(ctrl_q[CTRL_W-1:INC_W]), .step(step)
  );

  systime_accum #(.TIME_W(TIME_W), .INC_W(INC_W)) u_acc (
    .clk(clk), .rst(rst), .step(step), .inc(ctrl_q[INC_W-1:0]),
    .load(load), .load_val(load_val), .time_q(time_q)
  );

  AST_OFF_NO_CHANGE: assert property (@(posedge clk) disable iff (rst)
    (($past(ctrl_q[CTRL_W-1:INC_W]) == '0) && !$past(load)) |-> $stable(time_q)); // R5
endmodule

// File: tb/systime_counter_tb.sv
module systime_counter_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        rd_valid;

  int vectors = 0, miscompares = 0, cycles = 0;

  systime_counter dut_i (.clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .rd_valid(rd_valid));

  always #2 clk = ~clk;

  // behavioural reference
  longint unsigned m_time;
  bit [31:0] m_ctrl, m_stage, m_shadow, m_rdata;
  bit        m_valid;
  int        m_div;

  always @(posedge clk) begin
    int per; bit stp, rs;
    if (rst) begin
      m_time <= 0; m_ctrl <= 0; m_stage <= 0; m_shadow <= 0;
      m_rdata <= 0; m_valid <= 0; m_div <= 0;
    end else begin
      per = int'(m_ctrl[31:24]);
      rs  = wr_en && (addr == 2'd1 || addr == 2'd2);
      stp = (per != 0) && (m_div == per - 1) && !rs;
      m_valid <= rd_en;
      if (rd_en) begin
        if (addr == 2'd0) begin m_rdata <= m_time[31:0]; m_shadow <= m_time[63:32]; end
        else if (addr == 2'd1) m_rdata <= m_shadow;
        else if (addr == 2'd2) m_rdata <= m_ctrl;
        else m_rdata <= 0;
      end
      if (wr_en && addr == 2'd1) m_time <= {wr_data, m_stage};
      else if (stp) m_time <= m_time + longint'(m_ctrl[23:0]);
      if (rs || per == 0 || m_div == per - 1) m_div <= 0;
      else m_div <= m_div + 1;
      if (wr_en && addr == 2'd2) m_ctrl <= wr_data;
      if (wr_en && addr == 2'd0) m_stage <= wr_data;
    end
  end

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s: got %08h expected %08h", tag, got, exp);
    end
  endtask

  // per-cycle comparison against the model (R2 timing and all read data)
  always @(negedge clk) begin
    if (!rst) begin
      check("R2 valid", {31'd0, rd_valid}, {31'd0, m_valid});
      if (m_valid) check("R2 data", rd_data, m_rdata);
    end
  end

  task automatic cyc(bit w, bit r, bit [1:0] a, bit [31:0] d);
    wr_en = w; rd_en = r; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0; rd_en = 0;
  endtask

  task automatic rd(bit [1:0] a, output logic [31:0] v);
    cyc(0, 1, a, 0);
    v = rd_data;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0);
  endtask

  task automatic load(bit [31:0] hi, bit [31:0] lo);
    cyc(1, 0, 2'd0, lo);
    cyc(1, 0, 2'd1, hi);
  endtask

  initial begin
    while (cycles < 100000) begin @(posedge clk); cycles++; end
    miscompares++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [31:0] v, v2;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    rd(2'd0, v); check("R1 low", v, 0);
    rd(2'd1, v); check("R1 high", v, 0);
    rd(2'd2, v); check("R1 ctrl", v, 0);
    idle(5);
    rd(2'd0, v); check("R5 off after reset", v, 0);

    // R3/R4: period 3, value 5; 9 idle cycles after load -> 3 updates
    cyc(1, 0, 2'd2, {8'd3, 24'd5});
    load(32'd0, 32'd0);
    idle(9);
    rd(2'd0, v); check("R3 period 3 spacing", v, 32'd15);
    rd(2'd2, v); check("R2 ctrl readback", v, {8'd3, 24'd5});

    // R5: period 0 holds, R6: count kept across ctrl write
    cyc(1, 0, 2'd2, 32'd0);
    rd(2'd0, v); idle(6); rd(2'd0, v2);
    check("R5 hold", v2, v);
    check("R6 no reset on ctrl write", {31'd0, v != 0}, 32'd1);

    // R8: low write alone leaves count
    cyc(1, 0, 2'd0, 32'h1234_5678);
    rd(2'd0, v2); check("R8 staged only", v2, v);

    // R6: divider restart. load 100, ctrl P=4 V=7, 4 idles -> one update
    load(32'd0, 32'd100);
    cyc(1, 0, 2'd2, {8'd4, 24'd7});
    idle(4);
    rd(2'd0, v); check("R6 restart first update", v, 32'd107);

    // R9: wrap with carry; P=1 V=0x20 from FFFF_FFFF_FFFF_FFF0
    cyc(1, 0, 2'd2, {8'd1, 24'h20});
    load(32'hFFFF_FFFF, 32'hFFFF_FFF0);
    rd(2'd0, v); check("R8 atomic load low", v, 32'hFFFF_FFF0);
    rd(2'd1, v); check("R7 shadow high", v, 32'hFFFF_FFFF);
    cyc(1, 0, 2'd2, 32'd0);
    load(32'h0000_0007, 32'hFFFF_FFFC);
    cyc(1, 0, 2'd2, {8'd1, 24'd8});
    idle(1);
    cyc(1, 0, 2'd2, 32'd0);
    rd(2'd0, v); check("R9 carry low", v, 32'd4);
    rd(2'd1, v); check("R9 carry high", v, 32'd8);

    // R7: shadow not live; count moving, high read returns latched word
    cyc(1, 0, 2'd2, {8'd1, 24'hFF_FFFF});
    load(32'd0, 32'hFF00_0000);
    rd(2'd0, v);
    idle(3);
    rd(2'd1, v2); check("R7 shadow not live", v2, 32'd0);

    // R10: spare address
    cyc(1, 0, 2'd2, 32'd0);
    rd(2'd0, v);
    cyc(1, 0, 2'd3, 32'hDEAD_BEEF);
    rd(2'd3, v2); check("R10 spare reads zero", v2, 0);
    rd(2'd0, v2); check("R10 spare write ignored", v2, v);
    rd(2'd2, v2); check("R10 ctrl untouched", v2, 0);

    // random traffic, compared by the model each cycle
    for (int i = 0; i < 3000; i++) begin
      int k; bit [31:0] d;
      k = $urandom_range(0, 9);
      d = $urandom;
      if (k == 0) d = {8'($urandom_range(0, 4)), (i % 7 == 0) ? 24'hFF_FFFF : d[23:0]};
      case (k)
        0: cyc(1, 0, 2'd2, d);
        1: cyc(1, 0, 2'd0, d);
        2: cyc(1, 0, 2'd1, d);
        3, 4: cyc(0, 1, 2'd0, 0);
        5: cyc(0, 1, 2'd1, 0);
        6: cyc(0, 1, 2'($urandom_range(2, 3)), 0);
        default: cyc(0, 0, 0, 0);
      endcase
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule